// File: doc/BRIEF.md
# Banked Special-Function-Register GPIO Port Controller

This block holds the software-visible state of two 8-bit general-purpose I/O ports, called Port 1 and Port 3, on an 8-bit special-function-register bus. Each port has three registers: a data latch, a direction register and an alternate-select register. Each port's data latch and direction register share one bus address. A global remap input decides which of the two that address reaches, so that address space stays small. The alternate-select registers each have an address of their own.

Every pin is driven either from its port latch or from a peripheral signal, chosen by its alternate-select bit. Each pad appears as three separate vectors: output value, output enable and input. Peripherals are outside the block and connect only through plain vectors. Some alternate functions are input-only: receive data, an interrupt input and a trap input. When one of these is selected, the block forces that pin's output enable low. Pad inputs are always passed through to the peripheral input vectors.

The register bus is a single-cycle strobe interface with no back-pressure. A write is accepted on the clock edge at which `bus_we_i` is high. A read is a combinational lookup that is valid during the same cycle as `bus_re_i`. Because no transfer can stall, the stream-style valid/ready handshake is not used here, and every pin is a plain control or data level.

Top module: `gpio_sfr_ports`

## Requirements
- R1: After reset, both data latches read 0xFF, and both direction and alternate-select registers read 0x00. As a result, every pad output is 1 and every output enable is 0.
- R2: While `remap_i` is 0, address 0x90 reads and writes the Port 1 data latch, and address 0xB0 reads and writes the Port 3 data latch. The direction registers are left unchanged.
- R3: While `remap_i` is 1, address 0x90 reads and writes the Port 1 direction register, and address 0xB0 reads and writes the Port 3 direction register. The data latches are left unchanged.
- R4: The Port 1 alternate-select register is at 0xB4 and the Port 3 alternate-select register is at 0xB1, whatever the value of `remap_i`.
- R5: Pad output bit i equals the peripheral output bit i when alternate-select bit i is 1. Otherwise it equals data-latch bit i.
- R6: Pad output enable bit i equals direction bit i (1 = output). There is one exception: when the alternate-select bit is 1 on an input-only pin, the output enable is 0. The input-only pins are Port 1 bits 3 and 4 (mask 0x18) and Port 3 bit 1 (mask 0x02).
- R7: Each peripheral input vector equals its port's pad input vector in every cycle.
- R8: A write to any address other than 0x90, 0xB0, 0xB1 or 0xB4 changes no register, and a read from such an address returns 0x00.
- R9: A write changes its register at the next rising clock edge, and a read in the same cycle returns the old value. Read data follows the selected register combinationally and is 0x00 whenever `bus_re_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_i | input | 1 | Selects the direction registers at the shared addresses when 1 |
| bus_addr_i | input | 8 | Register bus address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, combinational |
| p1_pad_out_o | output | 8 | Port 1 pad output values |
| p1_pad_oe_o | output | 8 | Port 1 pad output enables |
| p1_pad_in_i | input | 8 | Port 1 pad input values |
| p1_periph_out_i | input | 8 | Peripheral signals to drive onto Port 1 pins |
| p1_periph_in_o | output | 8 | Port 1 pad inputs forwarded to peripherals |
| p3_pad_out_o | output | 8 | Port 3 pad output values |
| p3_pad_oe_o | output | 8 | Port 3 pad output enables |
| p3_pad_in_i | input | 8 | Port 3 pad input values |
| p3_periph_out_i | input | 8 | Peripheral signals to drive onto Port 3 pins |
| p3_periph_in_o | output | 8 | Port 3 pad inputs forwarded to peripherals |

## Verification
Directed sequences write each shared address with the remap input at both values, then read both banks back. This shows whether a write landed in the data latch or the direction register, and whether the other one stayed untouched. Alternate-select patterns that mix latch-driven and peripheral-driven pins are applied together with differing peripheral and latch values. This separates the two mux sources and exposes forced output enables on the input-only pins. Writes and reads to neighbouring unmapped addresses, reads with the strobe low, and a long stretch of random traffic with the remap input toggling are all compared against a behavioural register model on every clock. Together they expose decode aliasing and timing slips of one cycle.

// File: rtl/gpio_sfr_pkg.sv
`timescale 1ns/1ps
package gpio_sfr_pkg;

  localparam int unsigned BUS_W = 8;

  localparam logic [BUS_W-1:0] ADDR_P1_SHARED = 8'h90;
  localparam logic [BUS_W-1:0] ADDR_P3_SHARED = 8'hB0;
  localparam logic [BUS_W-1:0] ADDR_P3_ALT    = 8'hB1;
  localparam logic [BUS_W-1:0] ADDR_P1_ALT    = 8'hB4;

  localparam logic [BUS_W-1:0] DATA_RST_VAL = 8'hFF;
  localparam logic [BUS_W-1:0] DIR_RST_VAL  = 8'h00;
  localparam logic [BUS_W-1:0] ALT_RST_VAL  = 8'h00;

  // input-only alternate functions: rx data, interrupt 3, trap input
  localparam logic [BUS_W-1:0] P1_IN_ONLY = 8'h18;
  localparam logic [BUS_W-1:0] P3_IN_ONLY = 8'h02;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_P1_DATA = 3'd1,
    SEL_P1_DIR  = 3'd2,
    SEL_P1_ALT  = 3'd3,
    SEL_P3_DATA = 3'd4,
    SEL_P3_DIR  = 3'd5,
    SEL_P3_ALT  = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/gpio_sfr_decode.sv
`timescale 1ns/1ps
module gpio_sfr_decode
  import gpio_sfr_pkg::*;
(
  input  logic [BUS_W-1:0] addr_i,
  input  logic             remap_i,
  output reg_sel_e         sel_o
);

  always_comb begin
    unique case (addr_i)
      ADDR_P1_SHARED: sel_o = remap_i ? SEL_P1_DIR : SEL_P1_DATA;
      ADDR_P3_SHARED: sel_o = remap_i ? SEL_P3_DIR : SEL_P3_DATA;
      ADDR_P1_ALT:    sel_o = SEL_P1_ALT;
      ADDR_P3_ALT:    sel_o = SEL_P3_ALT;
      default:        sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs #(
  parameter int unsigned     W        = 8,
  parameter logic [W-1:0]    DATA_RST = '1,
  parameter logic [W-1:0]    DIR_RST  = '0,
  parameter logic [W-1:0]    ALT_RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_i,
  input  logic         wr_dir_i,
  input  logic         wr_alt_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] alt_o
);

  logic [W-1:0] data_q, dir_q, alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
    end else if (wr_data_i) begin
      data_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
    end else if (wr_dir_i) begin
      dir_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= ALT_RST;
    end else if (wr_alt_i) begin
      alt_q <= wdata_i;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign alt_o  = alt_q;

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_i |=> data_q == $past(wdata_i));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_i |=> dir_q == $past(wdata_i));

  assert_alt_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt_i |=> alt_q == $past(wdata_i));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_i |=> $stable(data_q));

  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir_i |=> $stable(dir_q));

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_data_i, wr_dir_i, wr_alt_i}) <= 1);

endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux #(
  parameter int unsigned  W            = 8,
  parameter logic [W-1:0] IN_ONLY_MASK = '0
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] periph_out_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] periph_in_o
);

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign pad_out_o[g] = alt_i[g] ? periph_out_i[g] : data_i[g];
    if (IN_ONLY_MASK[g]) begin : g_in_only
      assign pad_oe_o[g] = dir_i[g] & ~alt_i[g];
    end else begin : g_bidir
      assign pad_oe_o[g] = dir_i[g];
    end
  end

  assign periph_in_o = pad_in_i;

endmodule

// File: rtl/gpio_sfr_ports.sv
`timescale 1ns/1ps
module gpio_sfr_ports
  import gpio_sfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remap_i,
  input  logic [BUS_W-1:0] bus_addr_i,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  input  logic             bus_re_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic [BUS_W-1:0] p1_pad_out_o,
  output logic [BUS_W-1:0] p1_pad_oe_o,
  input  logic [BUS_W-1:0] p1_pad_in_i,
  input  logic [BUS_W-1:0] p1_periph_out_i,
  output logic [BUS_W-1:0] p1_periph_in_o,
  output logic [BUS_W-1:0] p3_pad_out_o,
  output logic [BUS_W-1:0] p3_pad_oe_o,
  input  logic [BUS_W-1:0] p3_pad_in_i,
  input  logic [BUS_W-1:0] p3_periph_out_i,
  output logic [BUS_W-1:0] p3_periph_in_o
);

  reg_sel_e sel;
  logic [BUS_W-1:0] p1_data, p1_dir, p1_alt;
  logic [BUS_W-1:0] p3_data, p3_dir, p3_alt;

  gpio_sfr_decode u_decode (
    .addr_i  (bus_addr_i),
    .remap_i (remap_i),
    .sel_o   (sel)
  );

  gpio_port_regs #(
    .W(BUS_W), .DATA_RST(DATA_RST_VAL), .DIR_RST(DIR_RST_VAL), .ALT_RST(ALT_RST_VAL)
  ) u_p1_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data_i (bus_we_i && sel == SEL_P1_DATA),
    .wr_dir_i  (bus_we_i && sel == SEL_P1_DIR),
    .wr_alt_i  (bus_we_i && sel == SEL_P1_ALT),
    .wdata_i   (bus_wdata_i),
    .data_o    (p1_data),
    .dir_o     (p1_dir),
    .alt_o     (p1_alt)
  );

  gpio_port_regs #(
    .W(BUS_W), .DATA_RST(DATA_RST_VAL), .DIR_RST(DIR_RST_VAL), .ALT_RST(ALT_RST_VAL)
  ) u_p3_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data_i (bus_we_i && sel == SEL_P3_DATA),
    .wr_dir_i  (bus_we_i && sel == SEL_P3_DIR),
    .wr_alt_i  (bus_we_i && sel == SEL_P3_ALT),
    .wdata_i   (bus_wdata_i),
    .data_o    (p3_data),
    .dir_o     (p3_dir),
    .alt_o     (p3_alt)
  );

  gpio_pin_mux #(.W(BUS_W), .IN_ONLY_MASK(P1_IN_ONLY)) u_p1_mux (
    .data_i       (p1_data),
    .dir_i        (p1_dir),
    .alt_i        (p1_alt),
    .periph_out_i (p1_periph_out_i),
    .pad_in_i     (p1_pad_in_i),
    .pad_out_o    (p1_pad_out_o),
    .pad_oe_o     (p1_pad_oe_o),
    .periph_in_o  (p1_periph_in_o)
  );

  gpio_pin_mux #(.W(BUS_W), .IN_ONLY_MASK(P3_IN_ONLY)) u_p3_mux (
    .data_i       (p3_data),
    .dir_i        (p3_dir),
    .alt_i        (p3_alt),
    .periph_out_i (p3_periph_out_i),
    .pad_in_i     (p3_pad_in_i),
    .pad_out_o    (p3_pad_out_o),
    .pad_oe_o     (p3_pad_oe_o),
    .periph_in_o  (p3_periph_in_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      unique case (sel)
        SEL_P1_DATA: bus_rdata_o = p1_data;
        SEL_P1_DIR:  bus_rdata_o = p1_dir;
        SEL_P1_ALT:  bus_rdata_o = p1_alt;
        SEL_P3_DATA: bus_rdata_o = p3_data;
        SEL_P3_DIR:  bus_rdata_o = p3_dir;
        SEL_P3_ALT:  bus_rdata_o = p3_alt;
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re_i |-> bus_rdata_o == '0);

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re_i && bus_addr_i != ADDR_P1_SHARED && bus_addr_i != ADDR_P3_SHARED &&
     bus_addr_i != ADDR_P1_ALT && bus_addr_i != ADDR_P3_ALT) |-> bus_rdata_o == '0);

  assert_p1_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p1_pad_out_o == ((p1_alt & p1_periph_out_i) | (~p1_alt & p1_data)));

  assert_p3_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p3_pad_out_o == ((p3_alt & p3_periph_out_i) | (~p3_alt & p3_data)));

  assert_p1_in_only_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_pad_oe_o & p1_alt & P1_IN_ONLY) == '0);

  assert_p3_in_only_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p3_pad_oe_o & p3_alt & P3_IN_ONLY) == '0);

  assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p1_periph_in_o == p1_pad_in_i && p3_periph_in_o == p3_pad_in_i);

endmodule

// File: tb/gpio_sfr_ports_bench.sv
`timescale 1ns/1ps
module gpio_sfr_ports_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] M1_IN_ONLY = 8'h18; // R6 mask, Port 1
  localparam logic [7:0] M3_IN_ONLY = 8'h02; // R6 mask, Port 3

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remap = 1'b0;
  logic [7:0] addr = 8'h00;
  logic we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic re = 1'b0;
  logic [7:0] rdata;
  logic [7:0] p1_out, p1_oe, p1_in, p1_pout, p1_pin;
  logic [7:0] p3_out, p3_oe, p3_in, p3_pout, p3_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [7:0] m_d1, m_r1, m_a1, m_d3, m_r3, m_a3;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sfr_ports u_gpio_sfr_ports (
    .clk(clk), .rst_n(rst_n), .remap_i(remap),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_re_i(re), .bus_rdata_o(rdata),
    .p1_pad_out_o(p1_out), .p1_pad_oe_o(p1_oe), .p1_pad_in_i(p1_in),
    .p1_periph_out_i(p1_pout), .p1_periph_in_o(p1_pin),
    .p3_pad_out_o(p3_out), .p3_pad_oe_o(p3_oe), .p3_pad_in_i(p3_in),
    .p3_periph_out_i(p3_pout), .p3_periph_in_o(p3_pin)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read();
    if (!re) return 8'h00;
    case (addr)
      8'h90:   return remap ? m_r1 : m_d1;
      8'hB0:   return remap ? m_r3 : m_d3;
      8'hB4:   return m_a1;
      8'hB1:   return m_a3;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_pad(input logic [7:0] d, input logic [7:0] a,
                                         input logic [7:0] p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = a[i] ? p[i] : d[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_oe(input logic [7:0] r, input logic [7:0] a,
                                        input logic [7:0] m);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = (a[i] && m[i]) ? 1'b0 : r[i];
    return o;
  endfunction

  task automatic compare_all(input string rtag);
    string t;
    if (!rst_n)                                t = "R1";
    else if (!re)                              t = "R9";
    else if (addr == 8'h90 || addr == 8'hB0)   t = remap ? "R3" : "R2";
    else if (addr == 8'hB1 || addr == 8'hB4)   t = "R4";
    else                                       t = "R8";
    if (rtag != "") t = rtag;
    chk(t, "rdata", rdata, exp_read());
    chk(rst_n ? "R5" : "R1", "p1 pad out", p1_out, exp_pad(m_d1, m_a1, p1_pout));
    chk(rst_n ? "R5" : "R1", "p3 pad out", p3_out, exp_pad(m_d3, m_a3, p3_pout));
    chk(rst_n ? "R6" : "R1", "p1 oe", p1_oe, exp_oe(m_r1, m_a1, M1_IN_ONLY));
    chk(rst_n ? "R6" : "R1", "p3 oe", p3_oe, exp_oe(m_r3, m_a3, M3_IN_ONLY));
    chk("R7", "p1 periph in", p1_pin, p1_in);
    chk("R7", "p3 periph in", p3_pin, p3_in);
  endtask

  // one bus cycle: drive after falling edge, compare, then apply the model at the edge
  task automatic cyc(input logic rm, input logic [7:0] a, input logic w,
                     input logic [7:0] wd, input logic r, input string rtag = "");
    remap = rm; addr = a; we = w; wdata = wd; re = r;
    #1;
    compare_all(rtag);
    @(posedge clk);
    if (rst_n && w) begin
      case (a)
        8'h90: if (rm) m_r1 = wd; else m_d1 = wd;
        8'hB0: if (rm) m_r3 = wd; else m_d3 = wd;
        8'hB4: m_a1 = wd;
        8'hB1: m_a3 = wd;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic read_all(input logic rm, input string rtag = "");
    cyc(rm, 8'h90, 1'b0, 8'h00, 1'b1, rtag);
    cyc(rm, 8'hB0, 1'b0, 8'h00, 1'b1, rtag);
    cyc(rm, 8'hB4, 1'b0, 8'h00, 1'b1, rtag);
    cyc(rm, 8'hB1, 1'b0, 8'h00, 1'b1, rtag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_d1 = 8'hFF; m_d3 = 8'hFF; m_r1 = 8'h00; m_r3 = 8'h00; m_a1 = 8'h00; m_a3 = 8'h00;
    p1_in = 8'hA5; p3_in = 8'h3C; p1_pout = 8'h00; p3_pout = 8'hFF;
    @(negedge clk);
    // R1: reset values, observed during and after reset
    cyc(1'b0, 8'h90, 1'b0, 8'h00, 1'b1);
    cyc(1'b1, 8'hB0, 1'b0, 8'h00, 1'b1);
    rst_n = 1'b1;
    read_all(1'b0, "R1");
    read_all(1'b1, "R1");

    // R2: data latches through shared addresses, direction untouched
    cyc(1'b0, 8'h90, 1'b1, 8'h5A, 1'b1, "R9"); // same-cycle read returns old value
    cyc(1'b0, 8'h90, 1'b0, 8'h00, 1'b1, "R2");
    cyc(1'b0, 8'hB0, 1'b1, 8'hC3, 1'b0);
    read_all(1'b0, "R2");
    read_all(1'b1, "R2");

    // R3: direction registers through shared addresses, latches untouched
    cyc(1'b1, 8'h90, 1'b1, 8'hFF, 1'b1);
    cyc(1'b1, 8'hB0, 1'b1, 8'hFF, 1'b1);
    read_all(1'b1, "R3");
    read_all(1'b0, "R3");

    // R4 with R5/R6: alt selects, peripheral values differ from latches
    p1_pout = 8'hA5; p3_pout = 8'h5A;
    cyc(1'b1, 8'hB4, 1'b1, 8'h1B, 1'b0, "R4");
    cyc(1'b0, 8'hB1, 1'b1, 8'hFF, 1'b0, "R4");
    read_all(1'b0, "R4");
    p1_pout = 8'h5A; p3_pout = 8'hA5; p1_in = 8'h0F; p3_in = 8'hF0;
    cyc(1'b0, 8'hB4, 1'b1, 8'hE4, 1'b1, "R4");
    cyc(1'b0, 8'hB1, 1'b1, 8'h02, 1'b1, "R4");
    cyc(1'b1, 8'h90, 1'b1, 8'h18, 1'b0, "R6");
    read_all(1'b1, "R6");

    // R8: unmapped writes ignored, reads zero
    cyc(1'b0, 8'h91, 1'b1, 8'h00, 1'b1, "R8");
    cyc(1'b1, 8'hB2, 1'b1, 8'h00, 1'b1, "R8");
    cyc(1'b0, 8'hB5, 1'b1, 8'h00, 1'b1, "R8");
    cyc(1'b0, 8'h10, 1'b1, 8'h00, 1'b1, "R8");
    cyc(1'b1, 8'hF0, 1'b1, 8'h00, 1'b1, "R8");
    read_all(1'b0, "R8");
    read_all(1'b1, "R8");

    // R9: read strobe low gives zero at mapped addresses
    cyc(1'b0, 8'h90, 1'b0, 8'h00, 1'b0, "R9");
    cyc(1'b1, 8'hB4, 1'b0, 8'h00, 1'b0, "R9");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] ra;
      case ($urandom_range(0, 5))
        0: ra = 8'h90;
        1: ra = 8'hB0;
        2: ra = 8'hB1;
        3: ra = 8'hB4;
        4: ra = 8'h91;
        default: ra = 8'($urandom);
      endcase
      p1_in = 8'($urandom); p3_in = 8'($urandom);
      p1_pout = 8'($urandom); p3_pout = 8'($urandom);
      cyc(1'($urandom), ra, 1'($urandom), 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule